// File: doc/BRIEF.md
# Floor Converter from Floating Point to Signed Integer

This unit turns one IEEE-754 operand, held either in single or double precision, into a signed two's-complement integer. The integer is either 32 or 64 bits wide. The conversion always rounds toward minus infinity: a positive value loses its fraction, and a negative value with any fraction moves to the next more negative integer. Any other rounding setting the surrounding core may hold has no effect on it. Subnormal operands are converted arithmetically, like every other finite value, and are never trapped.

A caller raises a one-cycle issue strobe together with the operand, a format code, a destination-width select and the invalid-trap enable. With the default build, one clock edge later the unit presents the integer, a write enable for the destination register, an invalid flag, an inexact flag and an exception request.

Some operands have no integer in the destination range: infinities, NaNs, and values whose floor falls outside that range. For these the unit either writes the largest positive integer of the destination width, or, when the trap is enabled, writes nothing and requests an exception. A parameter selects between registered outputs and purely combinational outputs.

Top module: `fp_floor_cvt`

## Requirements
- R1: With REG_OUT=1, an issue (req_i=1) sampled at a rising edge produces its outcome on the outputs right after that edge. In any cycle that follows an edge where req_i was 0, wr_o, inv_o, inx_o and exc_o are all 0 and res_o keeps its last written value. After reset every output is 0.
- R2: fmt_i value 17 selects double precision and uses all 64 bits of op_i. Any other value, nominally 16, selects single precision: op_i[31:0] holds the operand and op_i[63:32] is ignored.
- R3: The result is the floor of the operand. Positive fractions are dropped (2.7 gives 2). A negative value with a nonzero fraction gives the next more negative integer (-0.5 gives -1). A negative integral value is unchanged (-2.0 gives -2).
- R4: Positive zero and negative zero both give 0, with wr_o=1 and inv_o=0, inx_o=0.
- R5: inx_o is 1 exactly when the result is valid and nonzero fraction bits were discarded. inx_o is never 1 together with inv_o.
- R6: dst_i=0 selects a 32-bit word with valid range -2^31 to 2^31-1, returned sign-extended across the 64-bit res_o. dst_i=1 selects a 64-bit long with range -2^63 to 2^63-1.
- R7: A floor of exactly -2^31 (word) or -2^63 (long) is valid and raises no flag. A floor of exactly 2^31-1 is valid, and one of 2^31 is not.
- R8: inv_o is raised for an infinite operand, a NaN operand, or a floor outside the destination range. This holds however large the exponent is.
- R9: On an invalid case with inv_en_i=0, wr_o=1 and res_o is 2^31-1 (word) or 2^63-1 (long), for either operand sign.
- R10: On an invalid case with inv_en_i=1, wr_o=0 and exc_o=1, in the same cycle as inv_o=1, and res_o keeps its previous value.
- R11: Subnormal operands convert arithmetically with no trap. A positive one gives 0 and a negative one gives -1, both with inx_o=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Issue strobe for one conversion |
| op_i | input | 64 | Operand bits; single precision in [31:0] |
| fmt_i | input | 5 | Source format code: 17 double, otherwise single |
| dst_i | input | 1 | Destination width: 0 word, 1 long |
| inv_en_i | input | 1 | Trap enable for the invalid condition |
| res_o | output | LONG_W (64) | Integer result, sign-extended for word |
| wr_o | output | 1 | Destination write enable |
| inv_o | output | 1 | Invalid-operation flag |
| inx_o | output | 1 | Inexact flag |
| exc_o | output | 1 | Exception request |

## Verification
The bench aims at the edges of the ranges. It converts exactly -2^31 and -2^63, which a design using a symmetric limit would wrongly flag. It converts 2^31-1 and 2^31-1 plus one half, which an off-by-one limit would mishandle, and -2^31-0.5, which rounds past the word limit only because of the floor step. It checks negative fractions and negative subnormals, where a truncating design would return 0 or -2^31 instead of -1 or -2^31-1. It also drives negative overflow and NaN, where a design that saturated by sign would write the most negative integer instead of the positive default. Finally, it puts garbage in the upper operand half for single precision and enables the trap, to catch a design that still decodes those bits or still writes the destination.

// File: rtl/fpfl_pkg.sv
package fpfl_pkg;
   localparam int SGL_E   = 8;
   localparam int SGL_M   = 23;
   localparam int DBL_E   = 11;
   localparam int DBL_M   = 52;
   localparam int OP_W    = 1 + DBL_E + DBL_M;
   localparam int MAN_W   = DBL_M + 1;
   localparam int EXP_W   = DBL_E + 2;
   localparam int FMT_W   = 5;

   typedef struct packed {
      logic                    sign;
      logic                    special;
      logic signed [EXP_W-1:0] exp;
      logic [MAN_W-1:0]        man;
   } fpfl_unp_t;
endpackage

// File: rtl/fpfl_unpack.sv
module fpfl_unpack
   import fpfl_pkg::*;
#(
   parameter int FMT_DBL = 17
)(
   input  logic [OP_W-1:0]  op_i,
   input  logic [FMT_W-1:0] fmt_i,
   output fpfl_unp_t        unp_o
);
   fpfl_unp_t cand [2];

   for (genvar g = 0; g < 2; g++) begin : g_fmt
      localparam int EW   = (g == 0) ? SGL_E : DBL_E;
      localparam int MW   = (g == 0) ? SGL_M : DBL_M;
      localparam int BIAS = (1 << (EW - 1)) - 1;
      logic [EW-1:0] e_raw;
      logic [EW-1:0] e_eff;
      logic [MW-1:0] f_raw;
      logic          hidden;
      assign e_raw  = op_i[EW+MW-1:MW];
      assign f_raw  = op_i[MW-1:0];
      assign hidden = |e_raw;
      // subnormals share the smallest normal exponent
      assign e_eff  = hidden ? e_raw : EW'(1);
      assign cand[g].sign    = op_i[EW+MW];
      assign cand[g].special = &e_raw;
      assign cand[g].exp     = $signed(EXP_W'(e_eff) - EXP_W'(BIAS));
      assign cand[g].man     = MAN_W'({hidden, f_raw}) << (MAN_W - 1 - MW);
   end

   assign unp_o = (fmt_i == FMT_W'(FMT_DBL)) ? cand[1] : cand[0];
endmodule

// File: rtl/fpfl_align.sv
module fpfl_align
   import fpfl_pkg::*;
#(
   parameter int INT_W = 64
)(
   input  fpfl_unp_t    unp_i,
   output logic [INT_W:0] mag_o,
   output logic         lost_o,
   output logic         huge_o
);
   localparam int SH_W = MAN_W + INT_W;
   localparam int SA_W = $clog2(INT_W);

   logic [SH_W-1:0]  sh;
   logic [INT_W-1:0] ipart;

   always_comb begin
      sh     = '0;
      ipart  = '0;
      lost_o = 1'b0;
      huge_o = 1'b0;
      if (unp_i.exp >= $signed(EXP_W'(INT_W))) begin
         huge_o = 1'b1;
      end else if (unp_i.exp < 0) begin
         lost_o = |unp_i.man;
      end else begin
         sh     = SH_W'(unp_i.man) << unp_i.exp[SA_W-1:0];
         ipart  = sh[MAN_W-1 +: INT_W];
         lost_o = |sh[MAN_W-2:0];
      end
   end

   // floor: a negative value with a discarded fraction grows in magnitude
   assign mag_o = {1'b0, ipart} + (INT_W+1)'(unp_i.sign & lost_o);
endmodule

// File: rtl/fpfl_range.sv
module fpfl_range #(
   parameter int INT_W  = 64,
   parameter int WORD_W = 32
)(
   input  logic             sign_i,
   input  logic [INT_W:0]   mag_i,
   input  logic             huge_i,
   input  logic             special_i,
   input  logic             dst_i,
   output logic             ok_o,
   output logic [INT_W-1:0] val_o,
   output logic [INT_W-1:0] dflt_o
);
   logic [1:0]       fits;
   logic [INT_W-1:0] dflt [2];

   for (genvar g = 0; g < 2; g++) begin : g_dst
      localparam int DW = (g == 0) ? WORD_W : INT_W;
      localparam logic [INT_W:0] LIM = (INT_W+1)'(1) << (DW - 1);
      // negative side reaches one step further than the positive side
      assign fits[g] = sign_i ? (mag_i <= LIM) : (mag_i < LIM);
      assign dflt[g] = INT_W'(LIM - (INT_W+1)'(1));
   end

   assign ok_o   = !special_i && !huge_i && fits[dst_i];
   assign val_o  = sign_i ? (~mag_i[INT_W-1:0] + INT_W'(1)) : mag_i[INT_W-1:0];
   assign dflt_o = dflt[dst_i];
endmodule

// File: rtl/fp_floor_cvt.sv
module fp_floor_cvt
   import fpfl_pkg::*;
#(
   parameter int WORD_W  = 32,
   parameter int LONG_W  = 64,
   parameter int FMT_SGL = 16,
   parameter int FMT_DBL = 17,
   parameter bit REG_OUT = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic [OP_W-1:0]   op_i,
   input  logic [FMT_W-1:0]  fmt_i,
   input  logic              dst_i,
   input  logic              inv_en_i,
   output logic [LONG_W-1:0] res_o,
   output logic              wr_o,
   output logic              inv_o,
   output logic              inx_o,
   output logic              exc_o
);
   if (WORD_W < 2 || WORD_W >= LONG_W) begin : g_bad_w
      $error("fp_floor_cvt: WORD_W must lie in [2, LONG_W)");
   end
   if (FMT_SGL == FMT_DBL || FMT_DBL >= (1 << FMT_W)) begin : g_bad_fmt
      $error("fp_floor_cvt: format codes must differ and fit the field");
   end

   fpfl_unp_t         unp;
   logic [LONG_W:0]   mag;
   logic              lost, huge, ok;
   logic [LONG_W-1:0] val, dflt;
   logic              nx_wr, nx_inv, nx_inx, nx_exc;
   logic [LONG_W-1:0] nx_res;

   fpfl_unpack #(.FMT_DBL(FMT_DBL)) u_unpack (
      .op_i (op_i), .fmt_i (fmt_i), .unp_o (unp));

   fpfl_align #(.INT_W(LONG_W)) u_align (
      .unp_i (unp), .mag_o (mag), .lost_o (lost), .huge_o (huge));

   fpfl_range #(.INT_W(LONG_W), .WORD_W(WORD_W)) u_range (
      .sign_i (unp.sign), .mag_i (mag), .huge_i (huge),
      .special_i (unp.special), .dst_i (dst_i),
      .ok_o (ok), .val_o (val), .dflt_o (dflt));

   assign nx_wr  = req_i && (ok || !inv_en_i);
   assign nx_inv = req_i && !ok;
   assign nx_exc = req_i && !ok && inv_en_i;
   assign nx_inx = req_i && ok && lost;
   assign nx_res = ok ? val : dflt;

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            res_o <= '0;
            wr_o  <= 1'b0;
            inv_o <= 1'b0;
            inx_o <= 1'b0;
            exc_o <= 1'b0;
         end else begin
            wr_o  <= nx_wr;
            inv_o <= nx_inv;
            inx_o <= nx_inx;
            exc_o <= nx_exc;
            if (nx_wr) res_o <= nx_res;
         end
      end
   end else begin : g_comb
      assign res_o = nx_res;
      assign wr_o  = nx_wr;
      assign inv_o = nx_inv;
      assign inx_o = nx_inx;
      assign exc_o = nx_exc;
   end
endmodule

// File: rtl/fpfl_chk.sv
module fpfl_chk #(
   parameter int WORD_W  = 32,
   parameter int LONG_W  = 64,
   parameter int FMT_DBL = 17,
   parameter bit REG_OUT = 1'b1
)(
   input logic              clk,
   input logic              rst_n,
   input logic              req_i,
   input logic [63:0]       op_i,
   input logic [4:0]        fmt_i,
   input logic              dst_i,
   input logic              inv_en_i,
   input logic [LONG_W-1:0] res_o,
   input logic              wr_o,
   input logic              inv_o,
   input logic              inx_o,
   input logic              exc_o
);
   localparam logic [LONG_W-1:0] WMAX = LONG_W'((64'd1 << (WORD_W - 1)) - 64'd1);
   localparam logic [LONG_W-1:0] LMAX = {1'b0, {(LONG_W-1){1'b1}}};

   logic zero_in;
   assign zero_in = (fmt_i == 5'(FMT_DBL)) ? (op_i[62:0] == '0) : (op_i[30:0] == '0);

   p_suppress_r10: assert property (@(posedge clk) disable iff (!rst_n)
      exc_o |-> (inv_o && !wr_o));
   p_inexact_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
      inx_o |-> (wr_o && !inv_o));

   if (REG_OUT) begin : g_seq
      p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
         !$past(req_i) |-> (!wr_o && !inv_o && !inx_o && !exc_o));
      p_issue_answers_r1: assert property (@(posedge clk) disable iff (!rst_n)
         req_i |=> (wr_o || exc_o));
      p_default_value_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_o && inv_o) |-> (res_o == ($past(dst_i) ? LMAX : WMAX)));
      p_zero_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (req_i && zero_in) |=> (wr_o && !inv_o && !inx_o && res_o == '0));
      p_trap_no_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (req_i && inv_en_i) |=> !(inv_o && wr_o));
      p_res_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
         !wr_o |-> $stable(res_o));
   end
endmodule

bind fp_floor_cvt fpfl_chk #(
   .WORD_W (WORD_W), .LONG_W (LONG_W), .FMT_DBL (FMT_DBL), .REG_OUT (REG_OUT)
) u_fpfl_chk (
   .clk (clk), .rst_n (rst_n), .req_i (req_i), .op_i (op_i), .fmt_i (fmt_i),
   .dst_i (dst_i), .inv_en_i (inv_en_i), .res_o (res_o), .wr_o (wr_o),
   .inv_o (inv_o), .inx_o (inx_o), .exc_o (exc_o)
);

// File: tb/fp_floor_cvt_tb.sv
`timescale 1ns/1ps
module fp_floor_cvt_tb_top;
   localparam logic [4:0] F_S = 5'd16;
   localparam logic [4:0] F_D = 5'd17;
   localparam logic [63:0] WMAX = 64'h0000_0000_7FFF_FFFF;
   localparam logic [63:0] LMAX = 64'h7FFF_FFFF_FFFF_FFFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_i = 1'b0;
   logic [63:0] op_i = '0;
   logic [4:0]  fmt_i = F_S;
   logic        dst_i = 1'b0;
   logic        inv_en_i = 1'b0;
   logic [63:0] res_o;
   logic        wr_o, inv_o, inx_o, exc_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   fp_floor_cvt dut_i (
      .clk (clk), .rst_n (rst_n), .req_i (req_i), .op_i (op_i), .fmt_i (fmt_i),
      .dst_i (dst_i), .inv_en_i (inv_en_i), .res_o (res_o), .wr_o (wr_o),
      .inv_o (inv_o), .inx_o (inx_o), .exc_o (exc_o));

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // issue one conversion and sample right after the capturing edge
   task automatic conv(input logic [63:0] op, input logic [4:0] fmt,
                       input logic dst, input logic en);
      @(negedge clk);
      op_i = op; fmt_i = fmt; dst_i = dst; inv_en_i = en; req_i = 1'b1;
      @(negedge clk);
      req_i = 1'b0;
   endtask

   task automatic expect_out(input string tag, input logic [63:0] res,
                             input logic wr, input logic inv, input logic inx,
                             input logic exc);
      chk({tag, " res"}, res_o, res);
      chk({tag, " flags{wr,inv,inx,exc}"}, {60'd0, wr_o, inv_o, inx_o, exc_o},
          {60'd0, wr, inv, inx, exc});
   endtask

   task automatic t_reset;
      chk("R1 reset outputs", {res_o[59:0], wr_o, inv_o, inx_o, exc_o}, 64'd0);
   endtask

   task automatic t_rounding;
      conv(64'h4005_9999_9999_999A, F_D, 1'b1, 1'b0);
      expect_out("R3 2.7 long", 64'd2, 1, 0, 1, 0);
      conv(64'hBFE0_0000_0000_0000, F_D, 1'b1, 1'b0);
      expect_out("R3 -0.5 long", 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, 1, 0);
      conv(64'hC000_0000_0000_0000, F_D, 1'b0, 1'b0);
      expect_out("R3 -2.0 word", 64'hFFFF_FFFF_FFFF_FFFE, 1, 0, 0, 0);
      conv(64'h0000_0000_BFC0_0000, F_S, 1'b0, 1'b0);
      expect_out("R3 R5 -1.5f word", 64'hFFFF_FFFF_FFFF_FFFE, 1, 0, 1, 0);
      conv(64'h0000_0000_3FC0_0000, F_S, 1'b1, 1'b0);
      expect_out("R5 1.5f long", 64'd1, 1, 0, 1, 0);
   endtask

   task automatic t_format;
      conv(64'hDEAD_BEEF_42C8_0000, F_S, 1'b0, 1'b0);
      expect_out("R2 single ignores upper half", 64'd100, 1, 0, 0, 0);
      conv(64'hDEAD_BEEF_42C8_0000, 5'd3, 1'b0, 1'b0);
      expect_out("R2 non-17 code is single", 64'd100, 1, 0, 0, 0);
   endtask

   task automatic t_zero;
      conv(64'h8000_0000_0000_0000, F_D, 1'b1, 1'b0);
      expect_out("R4 -0.0 double", 64'd0, 1, 0, 0, 0);
      conv(64'h0000_0000_0000_0000, F_S, 1'b0, 1'b0);
      expect_out("R4 +0.0 single", 64'd0, 1, 0, 0, 0);
   endtask

   task automatic t_bounds;
      conv(64'hC1E0_0000_0000_0000, F_D, 1'b0, 1'b0);
      expect_out("R7 -2^31 word", 64'hFFFF_FFFF_8000_0000, 1, 0, 0, 0);
      conv(64'hC3E0_0000_0000_0000, F_D, 1'b1, 1'b0);
      expect_out("R7 -2^63 long", 64'h8000_0000_0000_0000, 1, 0, 0, 0);
      conv(64'h41DF_FFFF_FFC0_0000, F_D, 1'b0, 1'b0);
      expect_out("R7 2^31-1 word", WMAX, 1, 0, 0, 0);
      conv(64'h41DF_FFFF_FFE0_0000, F_D, 1'b0, 1'b0);
      expect_out("R6 2^31-0.5 word", WMAX, 1, 0, 1, 0);
      conv(64'h41E0_0000_0000_0000, F_D, 1'b0, 1'b0);
      expect_out("R7 R9 2^31 word", WMAX, 1, 1, 0, 0);
      conv(64'hC1E0_0000_0010_0000, F_D, 1'b0, 1'b0);
      expect_out("R6 R9 -2^31-0.5 word", WMAX, 1, 1, 0, 0);
      conv(64'hC1E0_0000_0010_0000, F_D, 1'b1, 1'b0);
      expect_out("R6 -2^31-0.5 long", 64'hFFFF_FFFF_7FFF_FFFF, 1, 0, 1, 0);
   endtask

   task automatic t_invalid;
      conv(64'h43E0_0000_0000_0000, F_D, 1'b1, 1'b0);
      expect_out("R8 R9 2^63 long", LMAX, 1, 1, 0, 0);
      conv(64'hC450_0000_0000_0000, F_D, 1'b1, 1'b0);
      expect_out("R8 R9 -2^70 long", LMAX, 1, 1, 0, 0);
      conv(64'h7FF8_0000_0000_0000, F_D, 1'b0, 1'b0);
      expect_out("R8 NaN word", WMAX, 1, 1, 0, 0);
      conv(64'h0000_0000_FF80_0000, F_S, 1'b1, 1'b0);
      expect_out("R8 -inf single long", LMAX, 1, 1, 0, 0);
   endtask

   task automatic t_trap;
      conv(64'd7 << 52 | 64'h4000_0000_0000_0000, F_D, 1'b1, 1'b1);
      expect_out("R10 valid with trap on", 64'd256, 1, 0, 0, 0);
      conv(64'h7FF0_0000_0000_0000, F_D, 1'b1, 1'b1);
      expect_out("R10 inf trapped keeps res", 64'd256, 0, 1, 0, 1);
   endtask

   task automatic t_idle;
      @(negedge clk);
      expect_out("R1 idle cycle", 64'd256, 0, 0, 0, 0);
   endtask

   task automatic t_subnormal;
      conv(64'h0000_0000_0000_0001, F_S, 1'b0, 1'b0);
      expect_out("R11 +subnormal single", 64'd0, 1, 0, 1, 0);
      conv(64'h8000_0000_0000_0001, F_D, 1'b1, 1'b0);
      expect_out("R11 -subnormal double", 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, 1, 0);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_bad++;
         n_chk++;
         $display("FAIL watchdog act=running exp=finished");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_rounding();
      t_format();
      t_zero();
      t_bounds();
      t_invalid();
      t_trap();
      t_idle();
      t_subnormal();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule